// File: doc/BRIEF.md
# Banded Frame Buffer Raster Scanout

This block turns a stored frame into a continuous, fixed-rate parallel pixel stream with data-enable, horizontal sync and vertical sync, ready for an external DVI transmitter. A host renders frames into memory at whatever rate it manages, through a write path that does not pass through this block. The scanout keeps the display refreshing at a constant rate whether the host renders many frames per second or less than one.

The frame buffer is not linear. The active screen is cut into vertical bands of `BAND_W` pixels, and each band has its own page in memory. For every raster position the block finds the band, the page and the offset inside it. It fetches 128-bit words, each holding four 32-bit pixels, ahead of time into a small FIFO. An output stage then unpacks each word into four pixels in raster order. Two whole frame buffers exist, and a select input chooses between them. The block applies a new selection only at the start of vertical blanking.

If the FIFO runs dry during active video, the block drives a fixed error colour and raises a sticky flag. At each vertical blanking start it flushes the FIFO and discards late memory replies, so the next frame starts clean.

Top module: `banded_scanout`

## Requirements
- R1: A line is `H_ACT+H_FP+H_SYNC+H_BP` pixel periods long and a frame is `V_ACT+V_FP+V_SYNC+V_BP` lines long. `pix_de` is high for the first `H_ACT` periods of each of the first `V_ACT` lines. The outputs are registered and show raster position p one cycle after the counter holds p. After reset the counter starts at the first line of vertical blanking (column 0, line `V_ACT`).
- R2: Both syncs are active high. `pix_hs` is high for `H_SYNC` periods, starting `H_ACT+H_FP` periods into each line. `pix_vs` is high for `V_SYNC` lines, starting at line `V_ACT+V_FP`. Neither sync is high while `pix_de` is high.
- R3: Active pixel (x, y) comes from memory word `sel*BUF_STRIDE + (x/BAND_W)*PAGE_STRIDE + y*(BAND_W/4) + (x mod BAND_W)/4`. A last band narrower than `BAND_W` is fetched only up to `H_ACT`.
- R4: Inside a word, pixel x uses bits `[(x mod 4)*32 +: 24]`, given out on `pix_rgb` as-is. The top byte of each 32-bit lane is ignored. `pix_rgb` is zero outside active video.
- R5: Reads are issued only while FIFO occupancy plus outstanding reads is below `FIFO_DEPTH`. Prefetch of a frame begins at its vertical blanking start. With granted requests and a fixed read latency, no underrun occurs and the FIFO never overflows.
- R6: `buf_sel` is captured only in the cycle the raster reaches vertical blanking start. The whole following frame is read from buffer `sel`, even if `buf_sel` changes during that frame.
- R7: If a pixel with x mod 4 = 0 needs a new word and the FIFO is empty, that pixel and the other three pixels of the same word slot show `ERR_RGB`, and `underrun` is set.
- R8: `underrun` stays set until a cycle with `clr_underrun` high clears it on the next edge. Clearing wins over setting in the same cycle.
- R9: At vertical blanking start the FIFO is flushed and replies to reads issued before that point are discarded. A frame that follows a starved frame, with memory granting again, is shown fully correct.
- R10: While `rst` is high, `pix_de`, `pix_hs`, `pix_vs`, `pix_rgb` and `underrun` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and memory clock |
| rst | input | 1 | Synchronous reset, active high |
| buf_sel | input | 1 | Frame buffer choice, applied at next vertical blanking start |
| clr_underrun | input | 1 | Clears the sticky underrun flag |
| mem_req | output | 1 | Read request for one word |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read reply valid (in request order) |
| mem_rdata | input | WORD_W | Read reply data |
| pix_rgb | output | 24 | Pixel colour, zero in blanking |
| pix_de | output | 1 | Active video |
| pix_hs | output | 1 | Horizontal sync, active high |
| pix_vs | output | 1 | Vertical sync, active high |
| underrun | output | 1 | Sticky FIFO underrun flag |

## Verification
Every pixel is given a colour that encodes its buffer, row and column, with a nonzero filler byte, and all pixels are compared across five frames. This separates wrong band or page arithmetic, wrong lane order and a leaked top byte. The buffer selection is flipped halfway through active video, which tells apart a capture only at vertical blanking from a capture at any time. One frame is starved by withholding grants, which exercises the error colour and the sticky flag. In the frame after it, grants come back just before blanking, so late replies reach the flush point; a correct next frame separates true discarding from a leftover misaligned word.

// File: rtl/fb_scan_pkg.sv
`timescale 1ns/1ps
package fb_scan_pkg;
    localparam int PIX_BITS = 32;
    localparam int RGB_BITS = 24;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/fb_raster_timing.sv
`timescale 1ns/1ps
module fb_raster_timing #(
    parameter int H_ACT  = 1600,
    parameter int H_FP   = 64,
    parameter int H_SYNC = 192,
    parameter int H_BP   = 304,
    parameter int V_ACT  = 1200,
    parameter int V_FP   = 1,
    parameter int V_SYNC = 3,
    parameter int V_BP   = 46,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    output logic                     act,
    output logic                     hs,
    output logic                     vs,
    output logic                     vb_start,
    output logic [$clog2(LANES)-1:0] lane
);
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam int LB    = $clog2(LANES);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } pos_t;

    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        if (pos_q.h == HW'(H_TOT - 1)) begin
            pos_d.h = '0;
            pos_d.v = (pos_q.v == VW'(V_TOT - 1)) ? '0 : pos_q.v + VW'(1);
        end else begin
            pos_d.h = pos_q.h + HW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q.h <= '0;
            pos_q.v <= VW'(V_ACT);
        end else begin
            pos_q <= pos_d;
        end
    end

    assign act      = (pos_q.h < HW'(H_ACT)) && (pos_q.v < VW'(V_ACT));
    assign hs       = (pos_q.h >= HW'(H_ACT + H_FP)) && (pos_q.h < HW'(H_ACT + H_FP + H_SYNC));
    assign vs       = (pos_q.v >= VW'(V_ACT + V_FP)) && (pos_q.v < VW'(V_ACT + V_FP + V_SYNC));
    assign vb_start = (pos_q.h == '0) && (pos_q.v == VW'(V_ACT));
    assign lane     = pos_q.h[LB-1:0];
endmodule

// File: rtl/fb_word_fifo.sv
`timescale 1ns/1ps
module fb_word_fifo #(
    parameter int WORD_W = 128,
    parameter int DEPTH  = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WORD_W-1:0]            wdata,
    input  logic                         pop,
    output logic [WORD_W-1:0]            head,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == CW'(DEPTH));
    assign count = ptr_q.cnt;
    assign head  = mem_q[ptr_q.rp];

    always_comb begin
        do_push = push && !full && !flush;
        do_pop  = pop && !empty && !flush;
        ptr_d   = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (do_push) ptr_d.wp = ptr_q.wp + AW'(1);
            if (do_pop)  ptr_d.rp = ptr_q.rp + AW'(1);
            ptr_d.cnt = ptr_q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[ptr_q.wp] <= wdata;
    end
endmodule

// File: rtl/fb_word_fetch.sv
`timescale 1ns/1ps
module fb_word_fetch #(
    parameter int H_ACT       = 1600,
    parameter int V_ACT       = 1200,
    parameter int LANES       = 4,
    parameter int BAND_W      = 136,
    parameter int PAGE_STRIDE = 65536,
    parameter int BUF_STRIDE  = 1048576,
    parameter int ADDR_W      = 21,
    parameter int DEPTH       = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         restart,
    input  logic                         buf_sel,
    input  logic [$clog2(DEPTH+1)-1:0]   fifo_count,
    output logic                         mem_req,
    output logic [ADDR_W-1:0]            mem_addr,
    input  logic                         mem_gnt,
    input  logic                         mem_rvalid,
    output logic                         push,
    output logic                         disp_buf,
    output logic                         pend_nz
);
    localparam int WPB     = BAND_W / LANES;
    localparam int WPR     = H_ACT / LANES;
    localparam int N_BANDS = fb_scan_pkg::ceil_div(H_ACT, BAND_W);
    localparam int BNW     = $clog2(N_BANDS + 1);
    localparam int WIBW    = $clog2(WPB + 1);
    localparam int WCW     = $clog2(WPR + 1);
    localparam int RW      = $clog2(V_ACT + 1);
    localparam int CNT_W   = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [BNW-1:0]   band;
        logic [WIBW-1:0]  wib;
        logic [WCW-1:0]   wcol;
        logic [RW-1:0]    row;
        logic             done;
        logic             bsel;
        logic [CNT_W-1:0] outst;
        logic [CNT_W-1:0] stale;
    } fetch_t;

    fetch_t fs_d, fs_q;
    logic credit, accept;

    assign credit   = ((CNT_W+1)'(fifo_count) + (CNT_W+1)'(fs_q.outst)) < (CNT_W+1)'(DEPTH);
    assign mem_req  = !fs_q.done && !restart && credit;
    assign accept   = mem_req && mem_gnt;
    assign mem_addr = ADDR_W'(BUF_STRIDE) * ADDR_W'(fs_q.bsel)
                    + ADDR_W'(PAGE_STRIDE) * ADDR_W'(fs_q.band)
                    + ADDR_W'(WPB) * ADDR_W'(fs_q.row)
                    + ADDR_W'(fs_q.wib);
    assign push     = mem_rvalid && (fs_q.stale == '0) && !restart;
    assign disp_buf = fs_q.bsel;
    assign pend_nz  = (fs_q.outst != '0) || (fs_q.stale != '0);

    always_comb begin
        fs_d = fs_q;
        if (restart) begin
            fs_d.band  = '0;
            fs_d.wib   = '0;
            fs_d.wcol  = '0;
            fs_d.row   = '0;
            fs_d.done  = 1'b0;
            fs_d.bsel  = buf_sel;
            fs_d.stale = fs_q.stale + fs_q.outst - CNT_W'(mem_rvalid);
            fs_d.outst = '0;
        end else begin
            if (mem_rvalid && (fs_q.stale != '0)) fs_d.stale = fs_q.stale - CNT_W'(1);
            fs_d.outst = fs_q.outst + CNT_W'(accept) - CNT_W'(push);
            if (accept) begin
                if (fs_q.wcol == WCW'(WPR - 1)) begin
                    fs_d.wcol = '0;
                    fs_d.wib  = '0;
                    fs_d.band = '0;
                    if (fs_q.row == RW'(V_ACT - 1)) fs_d.done = 1'b1;
                    else                            fs_d.row  = fs_q.row + RW'(1);
                end else begin
                    fs_d.wcol = fs_q.wcol + WCW'(1);
                    if (fs_q.wib == WIBW'(WPB - 1)) begin
                        fs_d.wib  = '0;
                        fs_d.band = fs_q.band + BNW'(1);
                    end else begin
                        fs_d.wib  = fs_q.wib + WIBW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_q      <= '0;
            fs_q.done <= 1'b1;
        end else begin
            fs_q <= fs_d;
        end
    end
endmodule

// File: rtl/banded_scanout.sv
`timescale 1ns/1ps
module banded_scanout #(
    parameter int H_ACT       = 1600,
    parameter int H_FP        = 64,
    parameter int H_SYNC      = 192,
    parameter int H_BP        = 304,
    parameter int V_ACT       = 1200,
    parameter int V_FP        = 1,
    parameter int V_SYNC      = 3,
    parameter int V_BP        = 46,
    parameter int WORD_W      = 128,
    parameter int BAND_W      = 136,
    parameter int PAGE_STRIDE = 65536,
    parameter int BUF_STRIDE  = 1048576,
    parameter int ADDR_W      = 21,
    parameter int FIFO_DEPTH  = 16,
    parameter logic [23:0] ERR_RGB = 24'hFF00FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_sel,
    input  logic              clr_underrun,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [23:0]       pix_rgb,
    output logic              pix_de,
    output logic              pix_hs,
    output logic              pix_vs,
    output logic              underrun
);
    import fb_scan_pkg::*;

    localparam int LANES = WORD_W / PIX_BITS;
    localparam int LB    = $clog2(LANES);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    logic             act, hs_raw, vs_raw, vb_start;
    logic [LB-1:0]    lane;
    logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [WORD_W-1:0] fifo_head;
    logic [CNT_W-1:0] fifo_count;
    logic             disp_buf, pend_nz;

    fb_raster_timing #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .LANES(LANES)
    ) u_timing (
        .clk(clk), .rst(rst), .act(act), .hs(hs_raw), .vs(vs_raw),
        .vb_start(vb_start), .lane(lane)
    );

    fb_word_fetch #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .LANES(LANES), .BAND_W(BAND_W),
        .PAGE_STRIDE(PAGE_STRIDE), .BUF_STRIDE(BUF_STRIDE),
        .ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)
    ) u_fetch (
        .clk(clk), .rst(rst), .restart(vb_start), .buf_sel(buf_sel),
        .fifo_count(fifo_count), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .push(fifo_push),
        .disp_buf(disp_buf), .pend_nz(pend_nz)
    );

    fb_word_fifo #(
        .WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk(clk), .rst(rst), .flush(vb_start), .push(fifo_push),
        .wdata(mem_rdata), .pop(fifo_pop), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
    );

    typedef struct packed {
        logic [WORD_W-1:0]   word;
        logic                ok;
        logic                de;
        logic                hs;
        logic                vs;
        logic [RGB_BITS-1:0] rgb;
        logic                flag;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d     = out_q;
        fifo_pop  = 1'b0;
        out_d.de  = act;
        out_d.hs  = hs_raw;
        out_d.vs  = vs_raw;
        out_d.rgb = '0;
        if (act) begin
            if (lane == '0) begin
                if (!fifo_empty) begin
                    fifo_pop   = 1'b1;
                    out_d.word = fifo_head;
                    out_d.ok   = 1'b1;
                    out_d.rgb  = fifo_head[RGB_BITS-1:0];
                end else begin
                    out_d.ok   = 1'b0;
                    out_d.rgb  = ERR_RGB;
                    out_d.flag = 1'b1;
                end
            end else if (out_q.ok) begin
                out_d.rgb = out_q.word[int'(lane)*PIX_BITS +: RGB_BITS];
            end else begin
                out_d.rgb = ERR_RGB;
            end
        end
        if (clr_underrun) out_d.flag = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign pix_rgb  = out_q.rgb;
    assign pix_de   = out_q.de;
    assign pix_hs   = out_q.hs;
    assign pix_vs   = out_q.vs;
    assign underrun = out_q.flag;
endmodule

// File: rtl/banded_scanout_chk.sv
`timescale 1ns/1ps
module banded_scanout_chk (
    input logic clk,
    input logic rst,
    input logic pix_de,
    input logic pix_hs,
    input logic pix_vs,
    input logic underrun,
    input logic clr_underrun,
    input logic fifo_push,
    input logic fifo_full,
    input logic vb_start,
    input logic disp_buf,
    input logic mem_rvalid,
    input logic pend_nz
);
    assert_sync_blank_R2: assert property (@(posedge clk) disable iff (rst)
        pix_de |-> (!pix_hs && !pix_vs))
        else $error("sync asserted during active video");

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        fifo_push |-> !fifo_full)
        else $error("word pushed into a full FIFO");

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_underrun) |=> underrun)
        else $error("underrun flag dropped without clear");

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr_underrun |=> !underrun)
        else $error("underrun flag survived clear");

    assert_buf_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(disp_buf) |-> $past(vb_start))
        else $error("displayed buffer changed outside blanking start");

    assert_reply_owned_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rvalid |-> pend_nz)
        else $error("read reply with no read pending");
endmodule

bind banded_scanout banded_scanout_chk u_chk (
    .clk(clk), .rst(rst), .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .underrun(underrun), .clr_underrun(clr_underrun), .fifo_push(fifo_push),
    .fifo_full(fifo_full), .vb_start(vb_start), .disp_buf(disp_buf),
    .mem_rvalid(mem_rvalid), .pend_nz(pend_nz)
);

// File: tb/banded_scanout_bench.sv
`timescale 1ns/1ps
module banded_scanout_bench;
    localparam int H_ACT = 20, H_FP = 2, H_SYNC = 3, H_BP = 3;
    localparam int V_ACT = 6,  V_FP = 1, V_SYNC = 2, V_BP = 2;
    localparam int HT  = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int VT  = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int FT  = HT * VT;
    localparam int VBL = (VT - V_ACT) * HT;
    localparam int BAND_W = 8, PAGE_STRIDE = 16, BUF_STRIDE = 64, ADDR_W = 7;
    localparam int LAT = 3, NF = 5;
    localparam logic [23:0] ERR = 24'hFF00FF;
    // fields: [3] buffer select, [2] starve, [1] clear after frame, [0] expected flag at frame end
    localparam logic [3:0] FRAME_TBL [NF] = '{4'b0000, 4'b1000, 4'b1101, 4'b0011, 4'b1000};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, buf_sel, clr_underrun, mem_req, mem_gnt, mem_rvalid;
    logic [ADDR_W-1:0] mem_addr;
    logic [127:0] mem_rdata;
    logic [23:0] pix_rgb;
    logic pix_de, pix_hs, pix_vs, underrun;

    banded_scanout #(
        .H_ACT(H_ACT), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_ACT(V_ACT), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .WORD_W(128), .BAND_W(BAND_W), .PAGE_STRIDE(PAGE_STRIDE),
        .BUF_STRIDE(BUF_STRIDE), .ADDR_W(ADDR_W), .FIFO_DEPTH(16), .ERR_RGB(ERR)
    ) u_banded_scanout (
        .clk(clk), .rst(rst), .buf_sel(buf_sel), .clr_underrun(clr_underrun),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .pix_rgb(pix_rgb),
        .pix_de(pix_de), .pix_hs(pix_hs), .pix_vs(pix_vs), .underrun(underrun)
    );

    // fixed-latency memory model
    logic [127:0]      mem [128];
    logic [ADDR_W-1:0] lat_addr [LAT];
    logic              lat_v [LAT];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) begin
                lat_v[i]    <= 1'b0;
                lat_addr[i] <= '0;
            end
        end else begin
            lat_v[0]    <= mem_req && mem_gnt;
            lat_addr[0] <= mem_addr;
            for (int i = 1; i < LAT; i++) begin
                lat_v[i]    <= lat_v[i-1];
                lat_addr[i] <= lat_addr[i-1];
            end
        end
    end
    assign mem_rvalid = lat_v[LAT-1];
    assign mem_rdata  = mem[lat_addr[LAT-1]];

    function automatic logic [23:0] pix_val(input int b, input int x, input int y);
        return {8'(b + 1), 8'(y), 8'(x)};
    endfunction

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        for (int a = 0; a < 128; a++) mem[a] = '0;
        for (int b = 0; b < 2; b++)
            for (int y = 0; y < V_ACT; y++)
                for (int x = 0; x < H_ACT; x++)
                    mem[b*BUF_STRIDE + (x/BAND_W)*PAGE_STRIDE + y*(BAND_W/4) + (x%BAND_W)/4]
                       [(x%4)*32 +: 32] = {8'hA5, pix_val(b, x, y)};

        rst = 1'b1;
        buf_sel = FRAME_TBL[0][3];
        mem_gnt = 1'b1;
        clr_underrun = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", "de in reset", 32'(pix_de), 32'd0);
        check("R10", "hs in reset", 32'(pix_hs), 32'd0);
        check("R10", "vs in reset", 32'(pix_vs), 32'd0);
        check("R10", "rgb in reset", 32'(pix_rgb), 32'd0);
        check("R10", "flag in reset", 32'(underrun), 32'd0);
        rst = 1'b0;

        for (int k = 1; k <= NF*FT; k++) begin
            int s, n, idx, h, v, b;
            logic e_de, e_hs, e_vs;
            logic [23:0] e_rgb;
            string tag;
            @(negedge clk);
            if (clr_underrun) begin
                clr_underrun = 1'b0;
                check("R8", "flag after clear", 32'(underrun), 32'd0);
            end
            s   = k - 1;
            n   = s / FT;
            idx = (V_ACT*HT + s) % FT;
            h   = idx % HT;
            v   = idx / HT;
            b   = int'(FRAME_TBL[n][3]);
            e_de = (h < H_ACT) && (v < V_ACT);
            e_hs = (h >= H_ACT + H_FP) && (h < H_ACT + H_FP + H_SYNC);
            e_vs = (v >= V_ACT + V_FP) && (v < V_ACT + V_FP + V_SYNC);
            e_rgb = '0;
            if (e_de) e_rgb = FRAME_TBL[n][2] ? ERR : pix_val(b, h, v);
            check("R1", "de", 32'(pix_de), 32'(e_de));
            check("R2", "hsync", 32'(pix_hs), 32'(e_hs));
            check("R2", "vsync", 32'(pix_vs), 32'(e_vs));
            if (FRAME_TBL[n][2])                          tag = "R7";
            else if (n > 0 && FRAME_TBL[n-1][2])          tag = "R9";
            else if (v >= V_ACT/2 && v < V_ACT && n + 1 < NF &&
                     FRAME_TBL[n+1][3] != FRAME_TBL[n][3]) tag = "R6";
            else if (!e_de)                               tag = "R4";
            else if (h % 4 != 0)                          tag = "R4";
            else                                          tag = "R3";
            check(tag, $sformatf("rgb f%0d x%0d y%0d", n, h, v), 32'(pix_rgb), 32'(e_rgb));

            // flag at the last cycle of each frame period
            if (s == (n+1)*FT - 1) begin
                if (FRAME_TBL[n][2])      tag = "R7";
                else if (FRAME_TBL[n][0]) tag = "R8";
                else                      tag = "R5";
                check(tag, $sformatf("flag end f%0d", n), 32'(underrun), 32'(FRAME_TBL[n][0]));
                if (FRAME_TBL[n][1]) clr_underrun = 1'b1;
            end
            // change selection halfway through active video of frame n
            if (n + 1 < NF && s == n*FT + VBL + HT*(V_ACT/2))
                buf_sel = FRAME_TBL[n+1][3];
            // grant control two cycles before the next blanking start
            if (n + 1 < NF && s == (n+1)*FT - 2)
                mem_gnt = !FRAME_TBL[n+1][2];
        end
        finished = 1;
        report();
    end
endmodule